// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block connects two shared data buses, side A and side B, through a number of independent lanes. By default there are two lanes of eight bits each. Every lane has its own control set. It can move data in either direction. It can pass the live value across, or it can pass a value captured earlier. A system can run the lanes separately, or tie their controls together so that they act as one wide path. Both buses are `inout` ports. A lane that is not driving a bus leaves it at high impedance.

Each lane holds two storage registers. The forward register samples bus A and the reverse register samples bus B. Loading is triggered by a rising edge on the lane's capture strobe for that register, and the strobe is sampled on the system clock. Capture works in every mode, including isolation. A lane's transfer mode is decoded from its active-low output enable and its direction bit into one of three states:

- `XM_ISOLATE`: `oe_n`=1, neither bus is driven.
- `XM_A_TO_B`: `oe_n`=0 and `dir`=1, bus B is driven.
- `XM_B_TO_A`: `oe_n`=0 and `dir`=0, bus A is driven.

Moving between these states is purely combinational, with no sequencing. For the driving direction, a per-direction select chooses between live data and stored data. A select of 0 passes the live opposite bus and a select of 1 passes the register. That choice goes through a hazard-covered multiplexer.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On a clock edge where `cap_ab[h]` is 1 and was 0 at the previous edge, lane h's forward register loads the value on its slice of bus A. The new value is visible after that edge.
- R2: On a clock edge where `cap_ba[h]` is 1 and was 0 at the previous edge, lane h's reverse register loads its slice of bus B in the same way.
- R3: Holding a capture strobe high over further edges does not reload the register. Only a low-to-high change of the strobe causes a load.
- R4: With `oe_n[h]`=1 (state `XM_ISOLATE`) the lane drives neither bus slice.
- R5: With `oe_n[h]`=0, `dir[h]`=1 and `sel_ab[h]`=0, bus B slice h equals the current bus A slice h combinationally.
- R6: With `oe_n[h]`=0, `dir[h]`=1 and `sel_ab[h]`=1, bus B slice h equals the forward register.
- R7: With `oe_n[h]`=0 and `dir[h]`=0, bus A slice h equals the live bus B slice when `sel_ba[h]`=0, and the reverse register when `sel_ba[h]`=1.
- R8: Capture does not depend on `oe_n` or `dir`. In isolation, both registers of a lane may load on the same edge.
- R9: A lane never drives both of its bus slices at once. The slice it does not drive carries only the external value.
- R10: Lane h occupies bits [h*HALF_W +: HALF_W] of both buses. Its controls have no effect on any other lane.
- R11: When the stored and live values are equal, toggling a select leaves the driven bus value unchanged on every cycle.
- R12: A clock edge with `rst_n`=0 clears both registers and the strobe history of every lane to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes and reset are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | N_HALF | Per-lane active-low output enable |
| dir | input | N_HALF | Per-lane direction: 1 drives B, 0 drives A |
| cap_ab | input | N_HALF | Per-lane strobe that loads the forward register from bus A |
| cap_ba | input | N_HALF | Per-lane strobe that loads the reverse register from bus B |
| sel_ab | input | N_HALF | Per-lane source for bus B: 0 live A, 1 stored |
| sel_ba | input | N_HALF | Per-lane source for bus A: 0 live B, 1 stored |
| a_bus | inout | HALF_W*N_HALF | Bus A |
| b_bus | inout | HALF_W*N_HALF | Bus B |

## Verification
The bench goes after the following corner cases, and what a faulty design would do in each:

- **Held strobe.** A strobe held high across several edges while bus A changes would, in a level-triggered design, replace the stored word with a later one.
- **Capture in isolation.** A design that gated capture with the enable would show a stale zero once stored mode is selected.
- **Overlap of lanes.** Sweeping both lanes with offset control patterns and different data exposes a lane whose slice overlaps its neighbour, or whose controls leak into it.
- **Reset.** Resets at start-up and mid-run catch registers that keep their data.
- **Select toggling.** Toggling the select while the live and stored values are equal catches a multiplexer that drops to a wrong value while switching.
- **Contention.** On the side that should be left alone, the bus reads back the external value, which exposes any contention from a lane driving both sides.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

    typedef enum logic [1:0] {
        XM_ISOLATE = 2'd0,
        XM_A_TO_B  = 2'd1,
        XM_B_TO_A  = 2'd2
    } xfer_mode_e;

endpackage

// File: rtl/xcvr_capture.sv
`timescale 1ns/1ps
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] store_q
);

    logic strobe_q;
    logic load;

    always_comb begin
        load = strobe && !strobe_q;
    end

    // Register process: strobe history and stored word (R1 R2 R3 R12)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            store_q  <= '0;
        end else begin
            strobe_q <= strobe;
            if (load) begin
                store_q <= din;
            end
        end
    end

    // R1
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !strobe_q) |=> (store_q == $past(din)));

    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && !strobe_q) |=> $stable(store_q));

    // R12
    cap_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (store_q == '0));

endmodule

// File: rtl/xcvr_sel_mux.sv
`timescale 1ns/1ps
module xcvr_sel_mux #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] held,
    output logic [W-1:0] out
);

    logic [W-1:0] sel_v;

    always_comb begin
        sel_v = {W{sel}};
        // The consensus term (held & live) keeps a bit steady while sel
        // moves, whenever both sources agree on that bit (R11).
        out = (sel_v & held) | (~sel_v & live) | (held & live);
    end

endmodule

// File: rtl/xcvr_half.sv
`timescale 1ns/1ps
module xcvr_half
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_drv,
    output logic         a_en,
    output logic [W-1:0] b_drv,
    output logic         b_en
);

    xfer_mode_e   mode;
    logic [W-1:0] reg_ab;
    logic [W-1:0] reg_ba;

    // R1 R8: forward register, loads regardless of mode
    xcvr_capture #(.W(W)) u_cap_ab (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (cap_ab),
        .din     (a_in),
        .store_q (reg_ab)
    );

    // R2 R8: reverse register
    xcvr_capture #(.W(W)) u_cap_ba (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (cap_ba),
        .din     (b_in),
        .store_q (reg_ba)
    );

    // R5 R6: source for bus B
    xcvr_sel_mux #(.W(W)) u_mux_b (
        .sel  (sel_ab),
        .live (a_in),
        .held (reg_ab),
        .out  (b_drv)
    );

    // R7: source for bus A
    xcvr_sel_mux #(.W(W)) u_mux_a (
        .sel  (sel_ba),
        .live (b_in),
        .held (reg_ba),
        .out  (a_drv)
    );

    // State decode
    always_comb begin
        unique case ({oe_n, dir})
            2'b00:   mode = XM_B_TO_A;
            2'b01:   mode = XM_A_TO_B;
            default: mode = XM_ISOLATE;
        endcase
    end

    // Output process
    always_comb begin
        a_en = 1'b0;
        b_en = 1'b0;
        unique case (mode)
            XM_A_TO_B:  b_en = 1'b1;
            XM_B_TO_A:  a_en = 1'b1;
            default:    ;
        endcase
    end

    // R9
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && b_en));

    // R4
    isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!a_en && !b_en));

    // R6
    stored_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && sel_ab) |-> (b_drv == reg_ab));

    // R5
    live_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && !sel_ab) |-> (b_drv == a_in));

    // R11
    no_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && $past(b_en) && $stable(a_in) && $stable(reg_ab) && (reg_ab == a_in))
        |-> $stable(b_drv));

endmodule

// File: rtl/dual_reg_xcvr.sv
`timescale 1ns/1ps
module dual_reg_xcvr #(
    parameter  int HALF_W = 8,
    parameter  int N_HALF = 2,
    localparam int BUS_W  = HALF_W * N_HALF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_HALF-1:0] oe_n,
    input  logic [N_HALF-1:0] dir,
    input  logic [N_HALF-1:0] cap_ab,
    input  logic [N_HALF-1:0] cap_ba,
    input  logic [N_HALF-1:0] sel_ab,
    input  logic [N_HALF-1:0] sel_ba,
    inout  wire  [BUS_W-1:0]  a_bus,
    inout  wire  [BUS_W-1:0]  b_bus
);

    logic [BUS_W-1:0]  a_drv;
    logic [BUS_W-1:0]  b_drv;
    logic [N_HALF-1:0] a_en;
    logic [N_HALF-1:0] b_en;

    // R10: lane h owns slice [h*HALF_W +: HALF_W]
    for (genvar h = 0; h < N_HALF; h++) begin : g_lane
        xcvr_half #(.W(HALF_W)) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .oe_n   (oe_n[h]),
            .dir    (dir[h]),
            .cap_ab (cap_ab[h]),
            .cap_ba (cap_ba[h]),
            .sel_ab (sel_ab[h]),
            .sel_ba (sel_ba[h]),
            .a_in   (a_bus[h*HALF_W +: HALF_W]),
            .b_in   (b_bus[h*HALF_W +: HALF_W]),
            .a_drv  (a_drv[h*HALF_W +: HALF_W]),
            .a_en   (a_en[h]),
            .b_drv  (b_drv[h*HALF_W +: HALF_W]),
            .b_en   (b_en[h])
        );

        assign a_bus[h*HALF_W +: HALF_W] = a_en[h] ? a_drv[h*HALF_W +: HALF_W] : {HALF_W{1'bz}};
        assign b_bus[h*HALF_W +: HALF_W] = b_en[h] ? b_drv[h*HALF_W +: HALF_W] : {HALF_W{1'bz}};
    end

endmodule

// File: tb/sim_dual_reg_xcvr.sv
`timescale 1ns/1ps
module sim_dual_reg_xcvr;

    localparam int W  = 8;
    localparam int NH = 2;
    localparam int BW = W * NH;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NH-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
    logic [BW-1:0] tb_a, tb_b;
    logic [NH-1:0] tb_a_oe, tb_b_oe;
    wire  [BW-1:0] a_bus;
    wire  [BW-1:0] b_bus;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [W-1:0] ref_ab [NH];
    logic [W-1:0] ref_ba [NH];
    logic         prev_ab [NH];
    logic         prev_ba [NH];
    logic [W-1:0] exp_a [NH];
    logic [W-1:0] exp_b [NH];

    always #2 clk = ~clk;

    for (genvar h = 0; h < NH; h++) begin : g_drv
        assign a_bus[h*W +: W] = tb_a_oe[h] ? tb_a[h*W +: W] : {W{1'bz}};
        assign b_bus[h*W +: W] = tb_b_oe[h] ? tb_b[h*W +: W] : {W{1'bz}};
    end

    dual_reg_xcvr #(.HALF_W(W), .N_HALF(NH)) u0 (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_bus(a_bus), .b_bus(b_bus)
    );

    task automatic check(input string tag, input int h, input string bus,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s lane %0d bus %s got %h expected %h", tag, h, bus, got, exp);
        end
    endtask

    // One cycle: set bus drives at negedge, check at negedge+1, update model at posedge
    task automatic run_cycle(input string tag);
        @(negedge clk);
        for (int h = 0; h < NH; h++) begin
            tb_a_oe[h] = !(!oe_n[h] && !dir[h]);
            tb_b_oe[h] = !(!oe_n[h] &&  dir[h]);
        end
        #1;
        for (int h = 0; h < NH; h++) begin
            string lbl_a, lbl_b;
            if (!oe_n[h] && dir[h]) begin
                exp_a[h] = tb_a[h*W +: W];
                exp_b[h] = sel_ab[h] ? ref_ab[h] : tb_a[h*W +: W];
                lbl_a = "R9";
                lbl_b = sel_ab[h] ? "R1 R6" : "R5";
            end else if (!oe_n[h]) begin
                exp_b[h] = tb_b[h*W +: W];
                exp_a[h] = sel_ba[h] ? ref_ba[h] : tb_b[h*W +: W];
                lbl_b = "R9";
                lbl_a = sel_ba[h] ? "R2 R7" : "R7";
            end else begin
                exp_a[h] = tb_a[h*W +: W];
                exp_b[h] = tb_b[h*W +: W];
                lbl_a = "R4";
                lbl_b = "R4";
            end
            check({tag, " ", lbl_a}, h, "A", a_bus[h*W +: W], exp_a[h]);
            check({tag, " ", lbl_b}, h, "B", b_bus[h*W +: W], exp_b[h]);
        end
        @(posedge clk);
        for (int h = 0; h < NH; h++) begin
            if (!rst_n) begin
                ref_ab[h] = '0; ref_ba[h] = '0; prev_ab[h] = 1'b0; prev_ba[h] = 1'b0;
            end else begin
                if (cap_ab[h] && !prev_ab[h]) ref_ab[h] = exp_a[h];
                if (cap_ba[h] && !prev_ba[h]) ref_ba[h] = exp_b[h];
                prev_ab[h] = cap_ab[h];
                prev_ba[h] = cap_ba[h];
            end
        end
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #800000;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        oe_n = '0; dir = '1; sel_ab = '1; sel_ba = '1; cap_ab = '0; cap_ba = '0;
        tb_a = 16'hA55A; tb_b = 16'h3CC3; tb_a_oe = '1; tb_b_oe = '1;
        for (int h = 0; h < NH; h++) begin
            ref_ab[h] = '0; ref_ba[h] = '0; prev_ab[h] = 1'b0; prev_ba[h] = 1'b0;
        end

        // R12 reset state: stored outputs read zero
        run_cycle("reset R12");
        run_cycle("reset R12");
        rst_n = 1'b1;
        run_cycle("reset R12");
        dir = '0;
        run_cycle("reset R12");

        // Sweep: offset control patterns per lane (R10, R8 in isolation)
        for (int c = 0; c < 512; c++) begin
            for (int h = 0; h < NH; h++) begin
                int k;
                k = c + h * 13;
                oe_n[h]   = ((k / 2) % 5) == 0;
                dir[h]    = k[3] ^ k[5];
                sel_ab[h] = k[2];
                sel_ba[h] = k[4];
                cap_ab[h] = k[0];
                cap_ba[h] = k[1] ^ k[6];
                tb_a[h*W +: W] = W'((k * 37 + h * 11) & 8'hFF);
                tb_b[h*W +: W] = W'((k * 91 + 5) & 8'hFF);
            end
            run_cycle("sweep R10 R8");
        end

        // R3: strobe held high must not reload
        oe_n = '0; dir = '1; sel_ab = '1; cap_ab = '0; cap_ba = '0;
        run_cycle("R3");
        cap_ab = '1; tb_a = 16'h5A5A;
        run_cycle("R3");
        for (int i = 0; i < 3; i++) begin
            tb_a = 16'hC3C3 + 16'(i);
            run_cycle("R3 held");
        end

        // R11: equal live and stored, toggle select each cycle
        tb_a = 16'h5A5A;
        for (int i = 0; i < 6; i++) begin
            sel_ab = i[0] ? 2'b11 : 2'b00;
            run_cycle("R11");
        end

        // R8: capture into both registers during isolation, then read back
        cap_ab = '0; oe_n = '1;
        run_cycle("R8");
        tb_a = 16'h3C3C; tb_b = 16'hE1E1; cap_ab = '1; cap_ba = '1;
        run_cycle("R8");
        cap_ab = '0; cap_ba = '0; oe_n = '0; dir = '1; sel_ab = '1;
        run_cycle("R8 stored");
        dir = '0; sel_ba = '1;
        run_cycle("R8 stored");

        // R12: reset mid-run clears stored data
        rst_n = 1'b0;
        run_cycle("R12 midrun");
        rst_n = 1'b1;
        run_cycle("R12 midrun");
        dir = '1;
        run_cycle("R12 midrun");

        finish_run();
    end

endmodule